// File: doc/BRIEF.md
# On-the-fly twiddle factor generator

This block streams the successive powers of a root of unity modulo a runtime modulus, for use by a number theoretic transform datapath. It keeps no table of factors. Each new factor is the previous one times a step value, reduced modulo q, and the result is held in a feedback register. Because the root and the modulus are only sampled at start, a different factor set can be used on every run just by presenting a different root. For the forward transform the root is W. For the inverse transform it is W^-1.

The parameter `LANES` (P) sets how many factors leave the block per cycle. With P = 1 the block is the serial form: one factor per accepted cycle, each stepping by W. With P > 1, lane j starts at W^j and every lane steps by W^P, so each group holds P consecutive powers.

Before streaming starts, a short setup phase uses the top lane's multiplier to produce the lane seeds W^0..W^(P-1) and the step W^P. The controller has four states:
- `ST_IDLE` goes to `ST_SEED` on start, or straight to `ST_STEP` when P = 1.
- `ST_SEED` lasts P-1 cycles. Each cycle it shifts the lanes down and multiplies the top lane by the root. It then goes to `ST_STEP`.
- `ST_STEP` spends one cycle forming W^P and goes to `ST_STREAM`.
- `ST_STREAM` presents groups under a valid/ready handshake. It returns to `ST_IDLE` when the final group is accepted.

Top module: `twiddle_gen`

## Requirements
- R1: After reset, `tw_valid` and `tw_last` are low and the block waits in idle.
- R2: A start pulse sampled in idle captures `root` and `modulus`. `tw_valid` first goes high after the P-th rising edge that follows the edge sampling start.
- R3: In group g, lane j carries root^(g·P+j) mod modulus at bits [j·WIDTH +: WIDTH] of `tw_data`. The first group is therefore root^0 .. root^(P-1).
- R4: With P = 1, each accepted cycle delivers the next single power, beginning at root^0.
- R5: A run delivers exactly N/P groups, with N = 2^LOG_N. `tw_last` is high only together with `tw_valid` on the final group.
- R6: In the cycle after the final group is accepted, `tw_valid` is low and the block is idle. A later start begins a fresh run.
- R7: While `tw_valid` is high and `tw_ready` is low, `tw_valid`, `tw_data` and `tw_last` hold. No factor is skipped or repeated.
- R8: A start pulse, or a change on `root` or `modulus`, while a run is in progress has no effect on that run.
- R9: Presenting the inverse root W^-1 yields the inverse powers in the same order. Back-to-back runs may use different moduli.
- R10: The reduction is exact for operands close to a modulus near 2^WIDTH. The full double-width product is reduced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled only in idle) |
| root | input | WIDTH | Root of unity: W for forward, W^-1 for inverse |
| modulus | input | WIDTH | Modulus q, at least 2, with root below q |
| tw_valid | output | 1 | Group of factors is valid |
| tw_ready | input | 1 | Consumer accepts the group |
| tw_data | output | LANES*WIDTH | P factors, lane j at bits [j*WIDTH +: WIDTH] |
| tw_last | output | 1 | Marks the final group of a run |

## Verification
The bench builds two copies with WIDTH = 16 and LOG_N = 5: one with LANES = 4 and one with LANES = 1. The four-lane copy covers the seeding shifts, the W^P step and eight-group runs. The serial copy covers the direct path from idle into the step state and a 32-factor stream. A 16-bit prime modulus of 65521 with roots near it exercises full-width products. Periodic ready stalls, together with a start pulse and changed inputs during a run, reach the hold and ignore paths.

// File: rtl/twg_pkg.sv
package twg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_STEP,
        ST_STREAM
    } twg_state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_ONE,
        OP_SHIFT,
        OP_MUL
    } twg_op_e;

endpackage

// File: rtl/twg_modmul.sv
module twg_modmul #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] m,
    output logic [WIDTH-1:0] r
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] full;
    logic [PW-1:0] rem;

    always_comb begin
        full = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
        if (m == '0) rem = '0;
        else         rem = full % {{WIDTH{1'b0}}, m};
        r = rem[WIDTH-1:0];
    end
endmodule

// File: rtl/twg_lane.sv
module twg_lane
    import twg_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  twg_op_e          op,
    input  logic [WIDTH-1:0] shift_in,
    input  logic [WIDTH-1:0] mul_b,
    input  logic [WIDTH-1:0] modulus,
    output logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] product
);
    twg_modmul #(.WIDTH(WIDTH)) u_mul (
        .a(value),
        .b(mul_b),
        .m(modulus),
        .r(product)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            unique case (op)
                OP_HOLD:  value <= value;
                OP_ONE:   value <= WIDTH'(1);
                OP_SHIFT: value <= shift_in;
                OP_MUL:   value <= product;
                default:  value <= value;
            endcase
        end
    end

    // A held lane keeps its factor (stall safety)
    assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(value));
endmodule

// File: rtl/twg_ctrl.sv
module twg_ctrl
    import twg_pkg::*;
#(
    parameter int LANES = 1,
    parameter int LOG_N = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ready,
    output logic load,
    output logic seeding,
    output logic stepping,
    output logic streaming,
    output logic valid,
    output logic last
);
    localparam int N      = 1 << LOG_N;
    localparam int GROUPS = N / LANES;
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int SW     = (LANES > 2) ? $clog2(LANES - 1) : 1;
    localparam logic [GW-1:0] GRP_MAX  = GW'(GROUPS - 1);
    localparam logic [SW-1:0] SEED_MAX = (LANES > 1) ? SW'(LANES - 2) : '0;

    twg_state_e state, next;
    logic [GW-1:0] grp_cnt;
    logic [SW-1:0] seed_cnt;
    logic          fire;
    logic          grp_final;

    assign fire      = (state == ST_STREAM) && ready;
    assign grp_final = (grp_cnt == GRP_MAX);

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:   if (start) next = (LANES > 1) ? ST_SEED : ST_STEP;
            ST_SEED:   if (seed_cnt == SEED_MAX) next = ST_STEP;
            ST_STEP:   next = ST_STREAM;
            ST_STREAM: if (fire && grp_final) next = ST_IDLE;
            default:   next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            grp_cnt  <= '0;
            seed_cnt <= '0;
        end else begin
            state <= next;
            if (state == ST_IDLE) begin
                grp_cnt  <= '0;
                seed_cnt <= '0;
            end else begin
                if (state == ST_SEED) seed_cnt <= seed_cnt + 1'b1;
                if (fire)             grp_cnt  <= grp_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        load      = 1'b0;
        seeding   = 1'b0;
        stepping  = 1'b0;
        streaming = 1'b0;
        unique case (state)
            ST_IDLE:   load      = start;
            ST_SEED:   seeding   = 1'b1;
            ST_STEP:   stepping  = 1'b1;
            ST_STREAM: streaming = 1'b1;
            default:   ;
        endcase
        valid = streaming;
        last  = streaming && grp_final;
    end

    assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seeding, stepping, streaming}));
    assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);
    assert_idle_after_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && last) |=> (!valid && state == ST_IDLE));
    assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid);
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && start && !(ready && last)) |=> streaming);
endmodule

// File: rtl/twiddle_gen.sv
module twiddle_gen
    import twg_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int LANES = 1,
    parameter int LOG_N = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WIDTH-1:0]       root,
    input  logic [WIDTH-1:0]       modulus,
    output logic                   tw_valid,
    input  logic                   tw_ready,
    output logic [LANES*WIDTH-1:0] tw_data,
    output logic                   tw_last
);
    localparam int TOP = LANES - 1;

    logic load, seeding, stepping, streaming;
    logic [WIDTH-1:0] root_q, mod_q, step_q, mul_b;
    logic [WIDTH-1:0] lane_val  [LANES];
    logic [WIDTH-1:0] lane_prod [LANES];
    twg_op_e          lane_op   [LANES];

    twg_ctrl #(.LANES(LANES), .LOG_N(LOG_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(tw_ready),
        .load(load), .seeding(seeding), .stepping(stepping),
        .streaming(streaming), .valid(tw_valid), .last(tw_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_q <= '0;
            mod_q  <= '0;
            step_q <= '0;
        end else begin
            if (load) begin
                root_q <= root;
                mod_q  <= modulus;
            end
            if (stepping) step_q <= lane_prod[TOP];
        end
    end

    assign mul_b = streaming ? step_q : root_q;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [WIDTH-1:0] shin;
        if (j < TOP) begin : g_mid
            assign shin = lane_val[j+1];
        end else begin : g_top
            assign shin = lane_val[j];
        end

        always_comb begin
            lane_op[j] = OP_HOLD;
            if (load)
                lane_op[j] = (j == TOP) ? OP_ONE : OP_HOLD;
            else if (seeding)
                lane_op[j] = (j == TOP) ? OP_MUL : OP_SHIFT;
            else if (streaming && tw_ready)
                lane_op[j] = OP_MUL;
        end

        twg_lane #(.WIDTH(WIDTH)) u_lane (
            .clk(clk), .rst_n(rst_n), .op(lane_op[j]), .shift_in(shin),
            .mul_b(mul_b), .modulus(mod_q),
            .value(lane_val[j]), .product(lane_prod[j])
        );

        assign tw_data[j*WIDTH +: WIDTH] = lane_val[j];
    end

    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_valid && !tw_ready) |=> ($stable(tw_data) && $stable(tw_last)));
    assert_root_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(root_q) && $stable(mod_q)));
endmodule

// File: tb/twiddle_gen_test.sv
module twiddle_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int LN = 5;
    localparam int N  = 1 << LN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_p = 1'b0, start_s = 1'b0;
    logic ready = 1'b1;
    logic [W-1:0] root_in = '0, mod_in = '0;
    logic v_p, v_s, l_p, l_s;
    logic [4*W-1:0] d_p;
    logic [W-1:0]   d_s;
    int checks = 0, errors = 0;
    bit ser_sel = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twiddle_gen #(.WIDTH(W), .LANES(4), .LOG_N(LN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start_p), .root(root_in),
        .modulus(mod_in), .tw_valid(v_p), .tw_ready(ready),
        .tw_data(d_p), .tw_last(l_p));

    twiddle_gen #(.WIDTH(W), .LANES(1), .LOG_N(LN)) uut_serial (
        .clk(clk), .rst_n(rst_n), .start(start_s), .root(root_in),
        .modulus(mod_in), .tw_valid(v_s), .tw_ready(ready),
        .tw_data(d_s), .tw_last(l_s));

    function automatic longint unsigned powm(longint unsigned b, longint unsigned e,
                                             longint unsigned m);
        longint unsigned r = 1 % m;
        b = b % m;
        while (e > 0) begin
            if (e[0]) r = (r * b) % m;
            b = (b * b) % m;
            e = e >> 1;
        end
        return r;
    endfunction

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic cur_valid();
        return ser_sel ? v_s : v_p;
    endfunction
    function automatic logic cur_last();
        return ser_sel ? l_s : l_p;
    endfunction
    function automatic logic [W-1:0] cur_lane(int j);
        return ser_sel ? d_s : d_p[j*W +: W];
    endfunction

    // One run on the chosen instance; checks every factor, last flag and end
    task automatic run_stream(bit ser, longint unsigned w, longint unsigned q,
                              bit stall, bit poke, string req);
        int lanes  = ser ? 1 : 4;
        int groups = N / lanes;
        int lat = 0, cyc = 0, g = 0;
        bit rdy;
        ser_sel = ser;
        @(negedge clk);
        root_in = W'(w); mod_in = W'(q); ready = 1'b1;
        if (ser) start_s = 1'b1; else start_p = 1'b1;
        @(negedge clk);
        start_s = 1'b0; start_p = 1'b0; lat = 1;
        while (!cur_valid() && lat < 20) begin
            @(negedge clk); lat++;
        end
        check(lat == lanes + 1, "R2 setup latency", lat, lanes + 1);
        if (poke) begin
            root_in = W'(w + 3); mod_in = W'(q - 2);
        end
        while (g < groups && cyc < 1000) begin
            check(cur_valid() == 1'b1, {req, " R7 valid during run"}, cur_valid(), 1);
            for (int j = 0; j < lanes; j++)
                check(cur_lane(j) == W'(powm(w, longint'(g * lanes + j), q)),
                      {req, " R3 factor"}, cur_lane(j), powm(w, longint'(g * lanes + j), q));
            check(cur_last() == (g == groups - 1), "R5 last flag", cur_last(), g == groups - 1);
            rdy = stall ? (cyc % 3 != 1) : 1'b1;
            ready = rdy;
            if (poke && cyc == 2) begin
                if (ser) start_s = 1'b1; else start_p = 1'b1;
            end
            @(negedge clk);
            start_s = 1'b0; start_p = 1'b0;
            cyc++;
            if (rdy) g++;
        end
        ready = 1'b1;
        check(g == groups, "R5 group count", g, groups);
        check(cur_valid() == 1'b0, "R6 idle after final group", cur_valid(), 0);
        check(cur_last() == 1'b0, "R6 last dropped", cur_last(), 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(v_p == 1'b0 && v_s == 1'b0, "R1 valid low after reset", {v_p, v_s}, 0);
        check(l_p == 1'b0 && l_s == 1'b0, "R1 last low after reset", {l_p, l_s}, 0);
    endtask

    task automatic test_forward();
        run_stream(1'b0, 28, 97, 1'b0, 1'b0, "R3 fwd P4");
        run_stream(1'b1, 28, 97, 1'b0, 1'b0, "R4 fwd serial");
    endtask

    task automatic test_stall_and_ignore();
        run_stream(1'b0, 5, 97, 1'b1, 1'b1, "R7 R8 P4");
        run_stream(1'b1, 5, 97, 1'b1, 1'b1, "R7 R8 serial");
    endtask

    task automatic test_inverse();
        longint unsigned wi = powm(28, 97 - 2, 97);
        check((wi * 28) % 97 == 1, "R9 inverse root sanity", (wi * 28) % 97, 1);
        run_stream(1'b0, wi, 97, 1'b0, 1'b0, "R9 inv P4");
        run_stream(1'b1, wi, 97, 1'b0, 1'b0, "R9 inv serial");
    endtask

    task automatic test_wide();
        longint unsigned q = 65521;
        longint unsigned wi = powm(65519, q - 2, q);
        run_stream(1'b0, 65519, q, 1'b0, 1'b0, "R10 wide P4");
        run_stream(1'b1, 65520, q, 1'b1, 1'b0, "R10 wide serial");
        run_stream(1'b0, wi, q, 1'b1, 1'b0, "R10 R9 wide inv P4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL timeout R6 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_forward();
        test_stall_and_ignore();
        test_inverse();
        test_wide();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule